// File: doc/BRIEF.md
# Chassis Intrusion Interrupt and Latch-Reset Pulser

This block serves one chassis-tamper pin that works in two directions. An external battery-backed circuit detects that the cover was opened, latches that event, and holds the pin high. The block reads the pin as an active-high input and raises an interrupt for as long as the pin stays high. The pin has an open-drain driver, so the block can only pull it low. Pulling it low is how the host resets the external latch.

The host has two command bits that clear themselves. One is in the configuration register and the other is in the intrusion-clear register. Writing a one to either bit starts the same timed low pulse on the pin. The pulse length is counted in strobes of a slow reference tick. While the block drives the pin low, the pin input is ignored, so the pulse cannot look like an intrusion. The input passes through a two-flop synchronizer and a debounce filter before it is used. The host can read a raw status bit, and an enable bit in the configuration register masks the interrupt.

Top module: `intrusion_guard`

## Requirements
- R1: After reset, `pin_pull_low`, `status` and `irq` are 0, and `cfg_rd` and `clr_rd` read 0.
- R2: When the pin is held high for at least DEB_CYC+2 clock cycles, `status` becomes 1, and `clr_rd` bit 0 shows it. When the pin returns low for long enough, `status` returns to 0.
- R3: A high level on the pin that lasts fewer than DEB_CYC consecutive clock cycles does not set `status`. A level lasting DEB_CYC cycles or more does set it.
- R4: `irq` is 1 only while `status` is 1 and the enable bit (configuration register bit 1) is 1. The enable bit does not change `status`. The enable bit reads back in `cfg_rd` bit 1.
- R5: A configuration write with data bit 6 set starts a low pulse. An intrusion-clear write with data bit 7 set also starts a low pulse. No other data bits start a pulse.
- R6: Once started, `pin_pull_low` stays 1 until the (PULSE_TICKS+1)-th `tick` strobe after the command. It falls at the clock edge that samples that strobe. The pulse therefore always spans at least PULSE_TICKS full tick periods.
- R7: A command that arrives while a pulse is running restarts the tick count. The pulse then ends on the (PULSE_TICKS+1)-th tick after the new command.
- R8: Both command bits clear themselves. `cfg_rd` bit 6 and `clr_rd` bit 7 always read 0.
- R9: While `pin_pull_low` is 1, `status` and `irq` are 0.
- R10: If the external latch is still set when a pulse ends, the high pin sets `status` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle reference tick strobe that times the pulse |
| pin_in | input | 1 | Level sensed on the tamper pin (high means an intrusion is latched) |
| pin_pull_low | output | 1 | 1 enables the open-drain pull-down on the pin |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| clr_wr | input | 1 | Write strobe for the intrusion-clear register |
| wr_data | input | 8 | Write data for both registers |
| cfg_rd | output | 8 | Configuration read value: bit 1 is the interrupt enable, bit 6 always reads 0 |
| clr_rd | output | 8 | Intrusion-clear read value: bit 0 is the status, bit 7 always reads 0 |
| status | output | 1 | Filtered intrusion status, not masked |
| irq | output | 1 | Masked intrusion interrupt |

## Verification
The hardest case to reach is a tamper latch that survives the reset pulse. While the block drives the pin low, the pin must read low. When the pulse ends, the pin must rise again. The bench models the external latch with a "stuck" option that keeps the latch from clearing. It checks that `status` stays low during the pulse and comes back after the pulse. Two exhaustive sweeps cover the other corners: one over all 256 write-data values on each register, and one over glitch widths on either side of the debounce length.

// File: rtl/intrusion_pkg.sv
package intrusion_pkg;
  localparam int REG_W       = 8;
  localparam int CFG_EN_BIT  = 1;  // interrupt enable in configuration register
  localparam int CFG_CMD_BIT = 6;  // self-clearing reset command, configuration register
  localparam int CLR_CMD_BIT = 7;  // self-clearing reset command, clear register
  localparam int CLR_STS_BIT = 0;  // status bit in clear register read value
endpackage

// File: rtl/intrusion_filter.sv
module intrusion_filter #(
  parameter int DEB_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic level
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic         s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (s2 == level) begin
      cnt <= '0;
    end else if (cnt == CW'(DEB_CYC - 1)) begin
      cnt   <= '0;
      level <= s2;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/intrusion_pulse.sv
module intrusion_pulse #(
  parameter int PULSE_TICKS = 450
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic active
);
  localparam int CW = $clog2(PULSE_TICKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active && tick) begin
      if (cnt == CW'(PULSE_TICKS)) active <= 1'b0;
      else                         cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/intrusion_guard.sv
module intrusion_guard
  import intrusion_pkg::*;
#(
  parameter int PULSE_TICKS = 450,
  parameter int DEB_CYC     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pin_in,
  output logic             pin_pull_low,
  input  logic             cfg_wr,
  input  logic             clr_wr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg_rd,
  output logic [REG_W-1:0] clr_rd,
  output logic             status,
  output logic             irq
);
  logic level, start, active;
  logic en_q, en_d, sts_d, irq_q;

  assign start = (cfg_wr && wr_data[CFG_CMD_BIT]) || (clr_wr && wr_data[CLR_CMD_BIT]);

  intrusion_filter #(.DEB_CYC(DEB_CYC)) i_filter (
    .clk(clk), .rst(rst), .raw(pin_in), .level(level)
  );

  intrusion_pulse #(.PULSE_TICKS(PULSE_TICKS)) i_pulse (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .active(active)
  );

  assign en_d  = cfg_wr ? wr_data[CFG_EN_BIT] : en_q;
  assign sts_d = level && !(active || start);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      status <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      status <= sts_d;
      irq_q  <= sts_d && en_d;
    end
  end

  assign irq          = irq_q;
  assign pin_pull_low = active;

  always_comb begin
    cfg_rd              = '0;
    cfg_rd[CFG_EN_BIT]  = en_q;
    clr_rd              = '0;
    clr_rd[CLR_STS_BIT] = status;
  end
endmodule

// File: rtl/intrusion_guard_chk.sv
module intrusion_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       cfg_wr,
  input logic       clr_wr,
  input logic [7:0] wr_data,
  input logic       pin_pull_low,
  input logic       status,
  input logic       irq
);
  // R4
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> status);

  // R5
  pulse_has_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pin_pull_low) |-> $past((cfg_wr && wr_data[6]) || (clr_wr && wr_data[7])));

  // R6
  pulse_ends_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_pull_low) |-> $past(tick));

  // R7
  restart_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_pull_low && ((cfg_wr && wr_data[6]) || (clr_wr && wr_data[7]))) |=> pin_pull_low);

  // R9
  quiet_during_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pin_pull_low |-> (!status && !irq));
endmodule

bind intrusion_guard intrusion_guard_chk i_chk (
  .clk(clk), .rst(rst), .tick(tick), .cfg_wr(cfg_wr), .clr_wr(clr_wr),
  .wr_data(wr_data), .pin_pull_low(pin_pull_low), .status(status), .irq(irq)
);

// File: tb/test_intrusion_guard.sv
module test_intrusion_guard;
  localparam int CLK_PERIOD = 10;
  localparam int PT         = 5;
  localparam int DB         = 4;
  localparam int TICK_DIV   = 4;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       pin_in;
  logic       pin_pull_low;
  logic       cfg_wr = 1'b0, clr_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] cfg_rd, clr_rd;
  logic       status, irq;

  logic ext_latch = 1'b0, stuck = 1'b0, set_req = 1'b0;
  logic glitch_mode = 1'b0, glitch_val = 1'b0;
  int   tcnt = 0, cyc = 0, errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    tcnt <= (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
    tick <= (tcnt == TICK_DIV-1);
    if (pin_pull_low && !stuck) ext_latch <= 1'b0;
    else if (set_req)           ext_latch <= 1'b1;
  end

  assign pin_in = glitch_mode ? glitch_val : (ext_latch && !pin_pull_low);

  intrusion_guard #(.PULSE_TICKS(PT), .DEB_CYC(DB)) i_intrusion_guard (
    .clk(clk), .rst(rst), .tick(tick), .pin_in(pin_in), .pin_pull_low(pin_pull_low),
    .cfg_wr(cfg_wr), .clr_wr(clr_wr), .wr_data(wr_data),
    .cfg_rd(cfg_rd), .clr_rd(clr_rd), .status(status), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input bit to_cfg, input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    if (to_cfg) cfg_wr = 1'b1; else clr_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    clr_wr = 1'b0;
    wr_data = '0;
  endtask

  task automatic wait_pulse_end();
    for (int i = 0; i < 400 && pin_pull_low; i++) @(negedge clk);
  endtask

  task automatic set_intrusion();
    @(negedge clk); set_req = 1'b1;
    @(negedge clk); set_req = 1'b0;
    cycles(DB + 6);
  endtask

  // count ticks seen while pulling low, starting at the negedge after the command edge
  task automatic count_pulse_ticks(output int nt);
    nt = 0;
    for (int i = 0; i < 400 && pin_pull_low; i++) begin
      if (tick) nt++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int nt;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!pin_pull_low && !status && !irq, "R1 outputs", {pin_pull_low, status, irq}, 0);
    chk(cfg_rd == 0 && clr_rd == 0, "R1 readback", {cfg_rd, clr_rd}, 0);

    // R5 R8 R4: exhaustive write-data sweep on both registers
    for (int r = 0; r < 2; r++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] dv;
        bit exp_p;
        dv = 8'(d);
        exp_p = (r == 0) ? dv[6] : dv[7];
        wr(r == 0, dv);
        chk(pin_pull_low == exp_p, "R5 pulse start", pin_pull_low, exp_p);
        chk(cfg_rd[6] == 1'b0 && clr_rd[7] == 1'b0, "R8 self-clear", {cfg_rd[6], clr_rd[7]}, 0);
        if (r == 0) chk(cfg_rd[1] == dv[1], "R4 enable readback", cfg_rd[1], dv[1]);
        wait_pulse_end();
      end
    end
    wr(1'b1, 8'h00);

    // R3 glitch width sweep
    for (int w = 1; w <= DB + 2; w++) begin
      bit seen;
      seen = 1'b0;
      @(negedge clk); glitch_mode = 1'b1; glitch_val = 1'b1;
      cycles(w);
      glitch_val = 1'b0;
      for (int i = 0; i < DB + 6; i++) begin
        @(negedge clk);
        if (status) seen = 1'b1;
      end
      chk(seen == (w >= DB), "R3 glitch width", seen, (w >= DB));
      cycles(DB + 6);
    end
    glitch_mode = 1'b0;
    cycles(DB + 6);

    // R2 R4 level follow and masking
    set_intrusion();
    chk(status && clr_rd[0], "R2 status set", {status, clr_rd[0]}, 3);
    chk(!irq, "R4 masked", irq, 0);
    wr(1'b1, 8'h02);
    chk(irq && status, "R4 enabled", {irq, status}, 3);
    wr(1'b1, 8'h00);
    chk(!irq && status, "R4 mask keeps status", {irq, status}, 1);
    wr(1'b1, 8'h02);

    // R6 R9 pulse length, quiet during pulse, latch cleared
    wr(1'b0, 8'h80);
    chk(!status && !irq, "R9 quiet", {status, irq}, 0);
    count_pulse_ticks(nt);
    chk(nt == PT + 1, "R6 pulse ticks", nt, PT + 1);
    cycles(DB + 6);
    chk(!status && !irq, "R2 cleared after pulse", {status, irq}, 0);

    // R7 restart mid-pulse
    wr(1'b1, 8'h42);
    cycles(2 * TICK_DIV + 1);
    wr(1'b1, 8'h42);
    count_pulse_ticks(nt);
    chk(nt == PT + 1, "R7 restart ticks", nt, PT + 1);

    // R10 stuck latch survives pulse
    stuck = 1'b1;
    set_intrusion();
    chk(status && irq, "R10 set before", {status, irq}, 3);
    wr(1'b0, 8'h80);
    cycles(TICK_DIV * 2);
    chk(!status, "R10 R9 quiet mid-pulse", status, 0);
    wait_pulse_end();
    cycles(DB + 6);
    chk(status && irq, "R10 returns", {status, irq}, 3);
    stuck = 1'b0;
    wr(1'b1, 8'h42);
    wait_pulse_end();
    cycles(DB + 6);
    chk(!status, "R10 finally cleared", status, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule